// File: doc/BRIEF.md
# Programmable Display Timing Generator

The block drives the horizontal sync, vertical sync and data-enable strobes of a parallel RGB video path from timing values held in a small register bank. Each scan line is built from four horizontal regions in this order: sync, back porch, active pixels, front porch. Each frame is built from the same four vertical regions counted in lines. A pixel column counter and a line counter come out alongside the strobes so that a pixel source downstream can address its data.

Software writes timing, polarity and vertical-sync delay values through a plain write port (address, 32-bit data, strobe). These writes land in a shadow set and do not disturb the frame on the wire. A write to the update register arms a request; at the last pixel of the current frame the whole shadow set is copied to the working set in a single step and the request drops. The next frame starts cleanly with the new values. The vertical sync pulse can be pushed later by a programmable number of pixel clocks, independently of the horizontal timing, and each of the three strobes has its own polarity bit.

Top module: `dtg_top`

## Requirements
- R1: While reset is held, hsync_o, vsync_o and de_o sit at their inactive levels for the reset polarity (all polarity bits 0, so all three outputs are 1), and pix_x_o and line_y_o are 0.
- R2: pix_x_o counts 0 up to (sync + back porch + active + front porch − 1) and wraps to 0; the horizontal sync is active for columns below the sync width.
- R3: line_y_o advances by one when pix_x_o wraps, and wraps to 0 after (vertical sync + back porch + active + front porch) lines.
- R4: The data-enable is active only where the column lies in [hsync+hbp, hsync+hbp+hact) and the line lies in [vsync+vbp, vsync+vbp+vact).
- R5: Control register (offset 0x00) bit 17 sets hsync polarity, bit 18 data-enable polarity, bit 19 vsync polarity; 1 means active-high, 0 means active-low.
- R6: Control bits 31:20 hold a vertical sync delay D; vsync is active for frame pixel positions p = line·htotal + column with D ≤ p < D + vsync_lines·htotal.
- R7: Writes to the control and timing registers change nothing at the outputs until an update request has been made and the current frame has ended.
- R8: A write of any value to offset 0x14 sets an update request; at the first frame end after it the shadow set is copied to the working set and the request clears, so later shadow writes without a new request have no effect.
- R9: Register layout: offset 0x04 holds horizontal back porch in bits 24:16 and sync width in bits 8:0; 0x08 holds horizontal front porch in bits 24:16 and active width in bits 10:0; 0x0C holds vertical back porch in bits 23:16 and sync lines in bits 7:0; 0x10 holds vertical front porch in bits 23:16 and active lines in bits 10:0. Writes to any other offset are ignored.
- R10: The strobes and the counter outputs are registered together, so the strobe levels seen in a cycle belong to the pix_x_o and line_y_o values seen in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 17 |
| vsync_o | output | 1 | Vertical sync, delayed, polarity per control bit 19 |
| de_o | output | 1 | Data enable, polarity per control bit 18 |
| pix_x_o | output | 13 | Column of the current pixel |
| line_y_o | output | 12 | Line of the current pixel |

## Verification
A wrong column or line count shows within one line as a strobe edge at the wrong pix_x_o, or as a counter that overshoots its programmed total; the stepping and bounds properties catch it on the very cycle it happens. A shadow copy taken at the wrong time shows as a changed line length before the frame boundary, or as a later write leaking through without a new request, which the bench sees within one or two frames by tracking the largest column reached. A mis-decoded field or delay shows at the fixed table of column and line points, where each strobe level is compared against values worked out from the programmed numbers.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Field widths fixed by the register layout
    localparam int HSW_W  = 9;
    localparam int HBP_W  = 9;
    localparam int HACT_W = 11;
    localparam int HFP_W  = 9;
    localparam int VSW_W  = 8;
    localparam int VBP_W  = 8;
    localparam int VACT_W = 11;
    localparam int VFP_W  = 8;
    localparam int VDLY_W = 12;

    // Counter widths large enough for the sum of all four regions
    localparam int HCW = 13;
    localparam int VCW = 12;
    localparam int FPW = HCW + VCW;

    // Register byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_HT1  = 'h04;
    localparam int OFS_HT2  = 'h08;
    localparam int OFS_VT1  = 'h0C;
    localparam int OFS_VT2  = 'h10;
    localparam int OFS_UPD  = 'h14;

    // Control register bit positions
    localparam int BIT_POL_HS = 17;
    localparam int BIT_POL_DE = 18;
    localparam int BIT_POL_VS = 19;
    localparam int DLY_LSB    = 20;

    typedef struct packed {
        logic              pol_hs;
        logic              pol_de;
        logic              pol_vs;
        logic [VDLY_W-1:0] vdly;
        logic [HSW_W-1:0]  hsw;
        logic [HBP_W-1:0]  hbp;
        logic [HACT_W-1:0] hact;
        logic [HFP_W-1:0]  hfp;
        logic [VSW_W-1:0]  vsw;
        logic [VBP_W-1:0]  vbp;
        logic [VACT_W-1:0] vact;
        logic [VFP_W-1:0]  vfp;
    } dtg_cfg_t;

    typedef struct packed {
        dtg_cfg_t shadow;
        dtg_cfg_t active;
        logic     pend;
    } rb_state_t;

    typedef struct packed {
        logic [FPW-1:0] fpix;
        logic           hs;
        logic           vs;
        logic           de;
        logic [HCW-1:0] x;
        logic [VCW-1:0] y;
    } os_state_t;

endpackage

// File: rtl/dtg_regbank.sv
module dtg_regbank
    import dtg_pkg::*;
#(
    parameter int       ADDR_W  = 8,
    parameter dtg_cfg_t RST_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              eof_i,
    output dtg_cfg_t          cfg_o,
    output logic              commit_o,
    output logic              pend_o
);

    rb_state_t st_d, st_q;
    logic      hit_ctrl, hit_ht1, hit_ht2, hit_vt1, hit_vt2, hit_upd;
    logic      unused_wd;

    assign unused_wd = ^wdata_i[15:11];

    always_comb begin
        hit_ctrl = we_i && (addr_i == ADDR_W'(OFS_CTRL));
        hit_ht1  = we_i && (addr_i == ADDR_W'(OFS_HT1));
        hit_ht2  = we_i && (addr_i == ADDR_W'(OFS_HT2));
        hit_vt1  = we_i && (addr_i == ADDR_W'(OFS_VT1));
        hit_vt2  = we_i && (addr_i == ADDR_W'(OFS_VT2));
        hit_upd  = we_i && (addr_i == ADDR_W'(OFS_UPD));
    end

    always_comb begin
        st_d     = st_q;
        commit_o = eof_i && st_q.pend;

        if (hit_ctrl) begin
            st_d.shadow.pol_hs = wdata_i[BIT_POL_HS];
            st_d.shadow.pol_de = wdata_i[BIT_POL_DE];
            st_d.shadow.pol_vs = wdata_i[BIT_POL_VS];
            st_d.shadow.vdly   = wdata_i[DLY_LSB +: VDLY_W];
        end
        if (hit_ht1) begin
            st_d.shadow.hbp = wdata_i[16 +: HBP_W];
            st_d.shadow.hsw = wdata_i[0 +: HSW_W];
        end
        if (hit_ht2) begin
            st_d.shadow.hfp  = wdata_i[16 +: HFP_W];
            st_d.shadow.hact = wdata_i[0 +: HACT_W];
        end
        if (hit_vt1) begin
            st_d.shadow.vbp = wdata_i[16 +: VBP_W];
            st_d.shadow.vsw = wdata_i[0 +: VSW_W];
        end
        if (hit_vt2) begin
            st_d.shadow.vfp  = wdata_i[16 +: VFP_W];
            st_d.shadow.vact = wdata_i[0 +: VACT_W];
        end

        // Whole-set copy at frame end; a request arriving now stays armed
        if (commit_o) begin
            st_d.active = st_q.shadow;
            st_d.pend   = 1'b0;
        end
        if (hit_upd) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= RST_CFG;
            st_q.active <= RST_CFG;
            st_q.pend   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.active;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] sw_i,
    input  logic [CW-1:0] bp_i,
    input  logic [CW-1:0] act_i,
    input  logic [CW-1:0] fp_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o,
    output logic          sync_o,
    output logic          act_o
);

    localparam int EW = CW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] total, act_start, act_end;

    always_comb begin
        total     = sw_i + bp_i + act_i + fp_i;
        act_start = sw_i + bp_i;
        act_end   = act_start + act_i;
        // Extended compare keeps a zero total from never wrapping
        last_o    = (EW'(cnt_q) + EW'(1)) >= EW'(total);
        sync_o    = cnt_q < sw_i;
        act_o     = (cnt_q >= act_start) && (cnt_q < act_end);

        cnt_d = cnt_q;
        if (step_i) begin
            cnt_d = last_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dtg_outstage.sv
module dtg_outstage
    import dtg_pkg::*;
#(
    parameter dtg_cfg_t RST_CFG = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  dtg_cfg_t       cfg_i,
    input  logic [HCW-1:0] hcnt_i,
    input  logic [VCW-1:0] vcnt_i,
    input  logic           hsync_i,
    input  logic           hact_i,
    input  logic           vact_i,
    input  logic           eof_i,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic [HCW-1:0] pix_x_o,
    output logic [VCW-1:0] line_y_o
);

    os_state_t      st_d, st_q;
    logic [HCW-1:0] htot;
    logic [FPW-1:0] vs_len, vs_beg, vs_end;
    logic           vs_on;

    function automatic logic drive_lvl(input logic act, input logic pol);
        return ~(act ^ pol);
    endfunction

    always_comb begin
        htot   = HCW'(cfg_i.hsw) + HCW'(cfg_i.hbp) + HCW'(cfg_i.hact) + HCW'(cfg_i.hfp);
        vs_len = FPW'(cfg_i.vsw) * FPW'(htot);
        vs_beg = FPW'(cfg_i.vdly);
        vs_end = vs_beg + vs_len;
        vs_on  = (st_q.fpix >= vs_beg) && (st_q.fpix < vs_end);

        st_d      = st_q;
        st_d.fpix = eof_i ? '0 : st_q.fpix + 1'b1;
        st_d.hs   = drive_lvl(hsync_i, cfg_i.pol_hs);
        st_d.vs   = drive_lvl(vs_on, cfg_i.pol_vs);
        st_d.de   = drive_lvl(hact_i && vact_i, cfg_i.pol_de);
        st_d.x    = hcnt_i;
        st_d.y    = vcnt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fpix <= '0;
            st_q.hs   <= ~RST_CFG.pol_hs;
            st_q.vs   <= ~RST_CFG.pol_vs;
            st_q.de   <= ~RST_CFG.pol_de;
            st_q.x    <= '0;
            st_q.y    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync_o  = st_q.hs;
    assign vsync_o  = st_q.vs;
    assign de_o     = st_q.de;
    assign pix_x_o  = st_q.x;
    assign line_y_o = st_q.y;

endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DEF_HSW  = 2,
    parameter int DEF_HBP  = 2,
    parameter int DEF_HACT = 4,
    parameter int DEF_HFP  = 2,
    parameter int DEF_VSW  = 1,
    parameter int DEF_VBP  = 1,
    parameter int DEF_VACT = 3,
    parameter int DEF_VFP  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [HCW-1:0]    pix_x_o,
    output logic [VCW-1:0]    line_y_o
);

    localparam dtg_cfg_t RST_CFG = '{
        pol_hs: 1'b0,
        pol_de: 1'b0,
        pol_vs: 1'b0,
        vdly:   '0,
        hsw:    HSW_W'(DEF_HSW),
        hbp:    HBP_W'(DEF_HBP),
        hact:   HACT_W'(DEF_HACT),
        hfp:    HFP_W'(DEF_HFP),
        vsw:    VSW_W'(DEF_VSW),
        vbp:    VBP_W'(DEF_VBP),
        vact:   VACT_W'(DEF_VACT),
        vfp:    VFP_W'(DEF_VFP)
    };

    dtg_cfg_t       cfg_act;
    logic           commit, upd_pend, eof;
    logic [HCW-1:0] h_cnt;
    logic [VCW-1:0] v_cnt;
    logic           h_last, v_last, h_sync, h_act, v_act;
    logic           unused_v_sync;

    assign eof = h_last && v_last;

    dtg_regbank #(
        .ADDR_W  (ADDR_W),
        .RST_CFG (RST_CFG)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .eof_i    (eof),
        .cfg_o    (cfg_act),
        .commit_o (commit),
        .pend_o   (upd_pend)
    );

    dtg_axis #(.CW(HCW)) u_hax (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (1'b1),
        .sw_i   (HCW'(cfg_act.hsw)),
        .bp_i   (HCW'(cfg_act.hbp)),
        .act_i  (HCW'(cfg_act.hact)),
        .fp_i   (HCW'(cfg_act.hfp)),
        .cnt_o  (h_cnt),
        .last_o (h_last),
        .sync_o (h_sync),
        .act_o  (h_act)
    );

    dtg_axis #(.CW(VCW)) u_vax (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (h_last),
        .sw_i   (VCW'(cfg_act.vsw)),
        .bp_i   (VCW'(cfg_act.vbp)),
        .act_i  (VCW'(cfg_act.vact)),
        .fp_i   (VCW'(cfg_act.vfp)),
        .cnt_o  (v_cnt),
        .last_o (v_last),
        .sync_o (unused_v_sync),
        .act_o  (v_act)
    );

    dtg_outstage #(.RST_CFG(RST_CFG)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg_act),
        .hcnt_i   (h_cnt),
        .vcnt_i   (v_cnt),
        .hsync_i  (h_sync),
        .hact_i   (h_act),
        .vact_i   (v_act),
        .eof_i    (eof),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .de_o     (de_o),
        .pix_x_o  (pix_x_o),
        .line_y_o (line_y_o)
    );

endmodule

// File: rtl/dtg_checks.sv
module dtg_checks
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [HCW-1:0]    pix_x_o,
    input logic [VCW-1:0]    line_y_o,
    input logic              hsync_o,
    input logic              de_o,
    input dtg_cfg_t          cfg_act,
    input logic              commit,
    input logic              upd_pend
);

    logic [HCW-1:0] h_total, h_a0, h_a1;
    logic [VCW-1:0] v_total, v_a0, v_a1;
    logic           upd_wr;

    always_comb begin
        h_a0    = HCW'(cfg_act.hsw) + HCW'(cfg_act.hbp);
        h_a1    = h_a0 + HCW'(cfg_act.hact);
        h_total = h_a1 + HCW'(cfg_act.hfp);
        v_a0    = VCW'(cfg_act.vsw) + VCW'(cfg_act.vbp);
        v_a1    = v_a0 + VCW'(cfg_act.vact);
        v_total = v_a1 + VCW'(cfg_act.vfp);
        upd_wr  = reg_we && (reg_addr == ADDR_W'(OFS_UPD));
    end

    p_xstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x_o != '0) |-> (pix_x_o == $past(pix_x_o) + 1'b1));

    p_xbound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> (pix_x_o < h_total));

    p_hsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit) && (hsync_o == cfg_act.pol_hs)) |-> (pix_x_o < HCW'(cfg_act.hsw)));

    p_ystep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x_o != '0) |-> $stable(line_y_o));

    p_ybound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> (line_y_o < v_total));

    p_de_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit) && (de_o == cfg_act.pol_de)) |->
        ((pix_x_o >= h_a0) && (pix_x_o < h_a1) && (line_y_o >= v_a0) && (line_y_o < v_a1)));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_act));

    p_req_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_wr |=> upd_pend);

    p_req_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !upd_wr) |=> !upd_pend);

endmodule

bind dtg_top dtg_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .pix_x_o  (pix_x_o),
    .line_y_o (line_y_o),
    .hsync_o  (hsync_o),
    .de_o     (de_o),
    .cfg_act  (cfg_act),
    .commit   (commit),
    .upd_pend (upd_pend)
);

// File: tb/sim_dtg_top.sv
`timescale 1ns/1ps
module sim_dtg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        hsync_o, vsync_o, de_o;
    logic [12:0] pix_x_o;
    logic [11:0] line_y_o;

    int nchk = 0;
    int nerr = 0;
    int maxx = 0;
    int maxy = 0;

    always #2.5 clk = ~clk;

    dtg_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o),
        .pix_x_o   (pix_x_o),
        .line_y_o  (line_y_o)
    );

    // Config B: hsw 3 hbp 1 hact 5 hfp 2 (11), vsw 2 vbp 2 vact 4 vfp 1 (9),
    // all polarities high, vsync delay 3 -> vsync over frame pixels [3,25).
    // Entry: {x[7:0], y[7:0], hs, vs, de}; same-cycle pairing covers R10.
    localparam logic [18:0] VEC [14] = '{
        {8'd0,  8'd0, 3'b100},
        {8'd2,  8'd0, 3'b100},
        {8'd3,  8'd0, 3'b010},
        {8'd10, 8'd0, 3'b010},
        {8'd1,  8'd1, 3'b110},
        {8'd5,  8'd1, 3'b010},
        {8'd2,  8'd2, 3'b110},
        {8'd3,  8'd2, 3'b000},
        {8'd4,  8'd4, 3'b001},
        {8'd8,  8'd4, 3'b001},
        {8'd9,  8'd4, 3'b000},
        {8'd3,  8'd5, 3'b000},
        {8'd4,  8'd7, 3'b001},
        {8'd6,  8'd8, 3'b000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_pt(input int x, input int y);
        int n = 0;
        while (!(int'(pix_x_o) == x && int'(line_y_o) == y)) begin
            @(negedge clk);
            if (int'(pix_x_o) > maxx) maxx = int'(pix_x_o);
            n++;
            if (n > 2000) begin
                check("R2 position not reached", {pix_x_o, line_y_o}, {x[12:0], y[11:0]});
                break;
            end
        end
    endtask

    task automatic scan(input int cycles);
        maxx = 0;
        maxy = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (int'(pix_x_o) > maxx) maxx = int'(pix_x_o);
            if (int'(line_y_o) > maxy) maxy = int'(line_y_o);
        end
    endtask

    initial begin
        #(200000 * 5);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset levels
        check("R1 hsync", hsync_o, 1);
        check("R1 vsync", vsync_o, 1);
        check("R1 de", de_o, 1);
        check("R1 x", pix_x_o, 0);
        check("R1 y", line_y_o, 0);

        rst_n = 1'b1;
        @(negedge clk);
        // Defaults: active-low, 10 px x 6 lines, delay 0
        check("R10 x at first cycle", pix_x_o, 0);
        check("R5 hsync active-low at x0", hsync_o, 0);
        check("R6 vsync active at p0 delay 0", vsync_o, 0);
        check("R4 de idle in sync", de_o, 1);

        wait_pt(2, 3);
        check("R2 hsync idle in back porch", hsync_o, 1);
        wait_pt(4, 3);
        check("R4 de active-low in window", de_o, 0);
        wait_pt(4, 5);
        check("R4 de idle in vertical front porch", de_o, 1);

        scan(70);
        check("R2 line length default", maxx, 9);
        check("R3 frame height default", maxy, 5);

        // Config B into shadow registers only (R9 layout)
        wr(8'h00, (32'd3 << 20) | (32'd7 << 17));
        wr(8'h04, (32'd1 << 16) | 32'd3);
        wr(8'h08, (32'd2 << 16) | 32'd5);
        wr(8'h0C, (32'd2 << 16) | 32'd2);
        wr(8'h10, (32'd1 << 16) | 32'd4);
        scan(70);
        check("R7 no change without update", maxx, 9);

        wr(8'h14, 32'd0);
        maxx = 0;
        wait_pt(0, 0);
        check("R7 old timing until frame end", maxx, 9);

        foreach (VEC[i]) begin
            wait_pt(int'(VEC[i][18:11]), int'(VEC[i][10:3]));
            check("R2 R5 R10 hsync", hsync_o, VEC[i][2]);
            check("R6 vsync delayed", vsync_o, VEC[i][1]);
            check("R4 de", de_o, VEC[i][0]);
        end

        scan(110);
        check("R8 committed line length", maxx, 10);
        check("R3 committed frame height", maxy, 8);

        // R9: unmapped offset ignored, shadow stays at B
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h14, 32'd0);
        repeat (100) @(negedge clk);
        scan(110);
        check("R9 unmapped write ignored", maxx, 10);

        // R8: request already consumed, new shadow value stays hidden
        wr(8'h08, (32'd2 << 16) | 32'd7);
        scan(220);
        check("R8 request cleared after commit", maxx, 10);
        wr(8'h14, 32'd0);
        repeat (110) @(negedge clk);
        scan(130);
        check("R8 second request commits", maxx, 12);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule